// File: doc/BRIEF.md
# Opcode-Triggered Software Breakpoint Controller

This block sits next to an 8-bit-opcode CPU core and turns one reserved opcode into a debug break. The core reports each executed opcode with a strobe, together with the address of the instruction that follows it. When the breakpoint enable bit is set and the reserved opcode (0xA5) executes, the block tells the core to bypass normal decode. It freezes the clocks of the four general timers and of the watchdog, and halts serial activity that is clocked from a timer. It also suspends the sequencer that guards timed-access protected registers. It then forces a jump to the debug vector 0x000083.

The return address is not pushed on the stack. It goes into three byte-wide registers (low, middle, extended) that software can read. A second 0xA5 executed while the break is active ends the break. It releases every freeze and jumps back to the saved address. When the enable bit is clear, 0xA5 is passed on to normal decode and the block does nothing.

Top module: `swbrk_ctrl`

## Requirements
- R1: `brk_hit` is 1 in the same cycle exactly when `exec_valid` is 1, `exec_opcode` equals 0xA5 and `brk_enable` is 1; otherwise it is 0.
- R2: A hit while `in_break` is 0 makes `pc_load` 1 with `pc_target` = 0x000083 on the next cycle, and `in_break` becomes 1 on that cycle.
- R3: On entry, `save_lo`, `save_mid` and `save_hi` take bits [7:0], [15:8] and [23:16] of `next_pc` on the next cycle.
- R4: While `in_break` is 1, all four bits of `tmr_clk_en` (bit i = timer i) and `wdt_clk_en` are 0, and `ser_halt` and `ta_suspend` are 1. While it is 0 the levels are reversed.
- R5: A hit while `in_break` is 1 makes `pc_load` 1 with `pc_target` equal to {`save_hi`,`save_mid`,`save_lo`} on the next cycle. On that same cycle `in_break` returns to 0 and the freezes of R4 are released.
- R6: The saved-address registers change only on a break entry. In particular they keep their value across an exit.
- R7: An executed 0xA5 with `brk_enable` at 0 changes no state, whether or not a break is active.
- R8: After reset, `in_break`, `pc_load`, `pc_target` and the saved bytes are all 0, and every clock enable is 1.
- R9: `pc_load` is a one-cycle pulse that only follows a hit. `pc_target` holds its value between hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_valid | input | 1 | An opcode executes this cycle |
| exec_opcode | input | 8 | Opcode being executed |
| next_pc | input | 24 | Address following the executing opcode |
| brk_enable | input | 1 | Breakpoint enable control bit |
| brk_hit | output | 1 | Opcode taken as a break; core bypasses normal decode |
| in_break | output | 1 | Breakpoint mode active |
| tmr_clk_en | output | 4 | Clock enables of timers 0 to 3 |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| ser_halt | output | 1 | Halts timer-clocked serial activity |
| ta_suspend | output | 1 | Suspends the timed-access sequencer |
| pc_load | output | 1 | One-cycle request to load the program counter |
| pc_target | output | 24 | Address to load |
| save_lo | output | 8 | Saved return address, bits 7:0 |
| save_mid | output | 8 | Saved return address, bits 15:8 |
| save_hi | output | 8 | Saved return address, bits 23:16 |

## Verification
`brk_hit` is combinational and is due in the cycle of the strobe. The bench therefore checks it a short delay after driving the inputs and before the next rising edge. Every other result passes through exactly one register. The jump request, the mode flag, the freezes and the saved bytes are all due one edge after the strobe. The bench's reference model advances at that edge, and every registered output is compared with it at the following falling edge, so each check sits one cycle after its stimulus.

// File: rtl/swbrk_pkg.sv
package swbrk_pkg;
  localparam int unsigned ADDR_W_DEF = 24;
  localparam int unsigned OP_W_DEF   = 8;
  localparam logic [7:0]  BRK_OP_DEF = 8'hA5;
  localparam logic [23:0] VECTOR_DEF = 24'h000083;

  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_HALTED = 1'b1
  } brk_state_e;
endpackage

// File: rtl/swbrk_fsm.sv
module swbrk_fsm
  import swbrk_pkg::*;
#(
  parameter int unsigned     ADDR_W = ADDR_W_DEF,
  parameter int unsigned     OP_W   = OP_W_DEF,
  parameter logic [OP_W-1:0] BRK_OP = BRK_OP_DEF,
  parameter logic [ADDR_W-1:0] VECTOR = VECTOR_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_valid,
  input  logic [OP_W-1:0]   exec_opcode,
  input  logic              brk_enable,
  input  logic [ADDR_W-1:0] saved_addr,
  output logic              brk_hit,
  output logic              halted,
  output logic              capture,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_target
);
  brk_state_e        state_q, state_d;
  logic              load_q, load_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;

  assign brk_hit = exec_valid && (exec_opcode == BRK_OP) && brk_enable;

  always_comb begin
    state_d = state_q;
    load_d  = 1'b0;
    tgt_d   = tgt_q;
    capture = 1'b0;
    if (brk_hit) begin
      load_d = 1'b1;
      if (state_q == ST_RUN) begin
        state_d = ST_HALTED;
        tgt_d   = VECTOR;
        capture = 1'b1;
      end else begin
        state_d = ST_RUN;
        tgt_d   = saved_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      load_q  <= 1'b0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      load_q  <= load_d;
      if (brk_hit) tgt_q <= tgt_d;
    end
  end

  assign halted    = (state_q == ST_HALTED);
  assign pc_load   = load_q;
  assign pc_target = tgt_q;

  p_entry_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_hit && !halted) |=> (pc_load && halted && pc_target == VECTOR));

  p_exit_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_hit && halted) |=> (pc_load && !halted && pc_target == $past(saved_addr)));

  p_load_after_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_hit |=> (!pc_load && $stable(pc_target)));

  p_disabled_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_opcode == BRK_OP && !brk_enable) |=> $stable(halted));
endmodule

// File: rtl/swbrk_retaddr.sv
module swbrk_retaddr
  import swbrk_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  localparam int unsigned NBYTES = ADDR_W / 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture,
  input  logic [ADDR_W-1:0]      ret_in,
  output logic [NBYTES-1:0][7:0] bytes_q
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [7:0] byte_d;
    assign byte_d = capture ? ret_in[b*8 +: 8] : bytes_q[b];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bytes_q[b] <= '0;
      else        bytes_q[b] <= byte_d;
    end
  end

  p_hold_unless_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(bytes_q));

  p_capture_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (bytes_q == $past(ret_in[NBYTES*8-1:0])));
endmodule

// File: rtl/swbrk_gates.sv
module swbrk_gates #(
  parameter int unsigned NUM_TIMERS = 4
) (
  input  logic                  halted,
  output logic [NUM_TIMERS-1:0] tmr_clk_en,
  output logic                  wdt_clk_en,
  output logic                  ser_halt,
  output logic                  ta_suspend
);
  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    assign tmr_clk_en[t] = !halted;
  end
  assign wdt_clk_en = !halted;
  assign ser_halt   = halted;
  assign ta_suspend = halted;
endmodule

// File: rtl/swbrk_ctrl.sv
module swbrk_ctrl
  import swbrk_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned ADDR_W     = ADDR_W_DEF,
  parameter int unsigned OP_W       = OP_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  exec_valid,
  input  logic [OP_W-1:0]       exec_opcode,
  input  logic [ADDR_W-1:0]     next_pc,
  input  logic                  brk_enable,
  output logic                  brk_hit,
  output logic                  in_break,
  output logic [NUM_TIMERS-1:0] tmr_clk_en,
  output logic                  wdt_clk_en,
  output logic                  ser_halt,
  output logic                  ta_suspend,
  output logic                  pc_load,
  output logic [ADDR_W-1:0]     pc_target,
  output logic [7:0]            save_lo,
  output logic [7:0]            save_mid,
  output logic [7:0]            save_hi
);
  localparam int unsigned NBYTES = ADDR_W / 8;

  logic                   capture;
  logic                   halted;
  logic [NBYTES-1:0][7:0] saved;

  swbrk_fsm #(
    .ADDR_W (ADDR_W),
    .OP_W   (OP_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_valid  (exec_valid),
    .exec_opcode (exec_opcode),
    .brk_enable  (brk_enable),
    .saved_addr  (saved),
    .brk_hit     (brk_hit),
    .halted      (halted),
    .capture     (capture),
    .pc_load     (pc_load),
    .pc_target   (pc_target)
  );

  swbrk_retaddr #(
    .ADDR_W (ADDR_W)
  ) u_ret (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .ret_in  (next_pc),
    .bytes_q (saved)
  );

  swbrk_gates #(
    .NUM_TIMERS (NUM_TIMERS)
  ) u_gates (
    .halted     (halted),
    .tmr_clk_en (tmr_clk_en),
    .wdt_clk_en (wdt_clk_en),
    .ser_halt   (ser_halt),
    .ta_suspend (ta_suspend)
  );

  assign in_break = halted;
  assign save_lo  = saved[0];
  assign save_mid = saved[1];
  assign save_hi  = saved[2];

  p_freeze_on_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_hit && !in_break) |=> (tmr_clk_en == '0 && !wdt_clk_en && ser_halt && ta_suspend));

  p_release_on_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_hit && in_break) |=> (tmr_clk_en == '1 && wdt_clk_en && !ser_halt && !ta_suspend && pc_load));
endmodule

// File: tb/test_swbrk_ctrl.sv
module test_swbrk_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_valid;
  logic [7:0]  exec_opcode;
  logic [23:0] next_pc;
  logic        brk_enable;
  logic        brk_hit, in_break, wdt_clk_en, ser_halt, ta_suspend, pc_load;
  logic [3:0]  tmr_clk_en;
  logic [23:0] pc_target;
  logic [7:0]  save_lo, save_mid, save_hi;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // reference model state
  bit        m_inb;
  bit        m_load;
  bit [23:0] m_tgt;
  bit [23:0] m_save;

  always #5 clk = ~clk;

  swbrk_ctrl i_swbrk_ctrl (
    .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .exec_opcode(exec_opcode),
    .next_pc(next_pc), .brk_enable(brk_enable), .brk_hit(brk_hit), .in_break(in_break),
    .tmr_clk_en(tmr_clk_en), .wdt_clk_en(wdt_clk_en), .ser_halt(ser_halt),
    .ta_suspend(ta_suspend), .pc_load(pc_load), .pc_target(pc_target),
    .save_lo(save_lo), .save_mid(save_mid), .save_hi(save_hi)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    chk("R2 R5 R9 pc_load", {31'd0, pc_load}, {31'd0, m_load});
    chk("R2 R5 R9 pc_target", {8'd0, pc_target}, {8'd0, m_tgt});
    chk("R2 R5 in_break", {31'd0, in_break}, {31'd0, m_inb});
    chk("R4 freeze levels", {26'd0, tmr_clk_en, wdt_clk_en, ser_halt, ta_suspend},
        {26'd0, {4{~m_inb}}, ~m_inb, m_inb, m_inb});
    chk("R3 R6 saved bytes", {8'd0, save_hi, save_mid, save_lo}, {8'd0, m_save});
  endtask

  // drive at a falling edge, check hit, advance model over the rising edge, check registers
  task automatic step(bit v, bit [7:0] op, bit [23:0] pc, bit en);
    bit hit;
    exec_valid = v; exec_opcode = op; next_pc = pc; brk_enable = en;
    #1;
    hit = v && (op == 8'hA5) && en;
    chk("R1 brk_hit", {31'd0, brk_hit}, {31'd0, hit});
    @(posedge clk);
    m_load = 1'b0;
    if (hit) begin
      m_load = 1'b1;
      if (!m_inb) begin m_inb = 1'b1; m_tgt = 24'h000083; m_save = pc; end
      else        begin m_inb = 1'b0; m_tgt = m_save; end
    end
    @(negedge clk);
    check_regs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; exec_valid = 1'b0; exec_opcode = '0; next_pc = '0; brk_enable = 1'b0;
    m_inb = 0; m_load = 0; m_tgt = '0; m_save = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check_regs();
    chk("R8 reset hit", {31'd0, brk_hit}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs();

    // R7: break opcode with enable clear passes through
    step(1, 8'hA5, 24'h000100, 0);
    chk("R7 no entry when disabled", {31'd0, in_break}, 32'd0);
    // other opcodes do nothing
    step(1, 8'h12, 24'h000101, 1);
    step(0, 8'hA5, 24'h000102, 1);
    // entry
    step(1, 8'hA5, 24'h123456, 1);
    step(0, 8'h00, 24'h000000, 1);
    step(1, 8'h74, 24'h000085, 1);
    // R7 inside break: disabled A5 keeps break active
    step(1, 8'hA5, 24'h000086, 0);
    chk("R7 break kept when disabled", {31'd0, in_break}, 32'd1);
    // exit
    step(1, 8'hA5, 24'h000087, 1);
    chk("R6 saved kept after exit", {8'd0, save_hi, save_mid, save_lo}, 32'h00123456);
    step(0, 8'h00, 24'h0, 1);
    // second entry/exit, back to back
    step(1, 8'hA5, 24'hFEDCBA, 1);
    step(1, 8'hA5, 24'h000084, 1);
    step(1, 8'hA5, 24'h00FF01, 1);
    step(1, 8'hA5, 24'h000084, 1);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      bit [7:0] op;
      op = ($urandom_range(0, 3) == 0) ? 8'hA5 : 8'($urandom);
      step(1'($urandom), op, 24'($urandom), ($urandom_range(0, 4) != 0));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule